// File: doc/BRIEF.md
# Successive-Approximation Controller with Sub-Array Handoff

This block is the digital controller of an N-bit successive-approximation converter. Its capacitor array is split into N-1 sub-arrays, and each sub-array gets the same bottom-plate switch commands. While the sample-rate clock is high, the sampling switches stay closed and every switch command stays low. A falling edge of the sample-rate clock starts a conversion. At that point only the first sub-array stays connected to the comparator, and the most significant bit is resolved at once, with no capacitor moved.

Each decision drives one positive-side or one negative-side switch line directly, with no decode step. After each switch update, a programmable settle wait runs before the next comparator strobe. As bits resolve, the comparator connection moves from one sub-array to the next. An internal ready flag decides, at the end of each comparison, whether to fire again or to publish the code and go back to sampling. A clashing or missing comparator answer aborts the conversion.

The self-timed comparator loop is modelled by a fast clock. The comparator is an external handshake: a strobe goes out, and a differential pair comes back that must return to all-low between comparisons.

Top module: `sar_handoff_ctrl`

## Requirements
- R1: After reset, `sampling` is 1, `sw_p` and `sw_n` are 0, `sub_sel` is all ones, and `cmp_start`, `done`, `err` and `code` are 0.
- R2: While `sampling` is 1, every bit of `sw_p` and `sw_n` is 0 and every sub-array select is closed (`sub_sel` all ones).
- R3: A falling edge of `smp_clk` seen while sampling starts a conversion. `sampling` drops, `sub_sel` becomes 1 (sub-array 0 only), and the first strobe is issued with all switch lines still 0.
- R4: A valid decision has exactly one of `cmp_p`/`cmp_n` high, and `cmp_p` alone means bit value 1. Decision k is counted from 0 at the MSB. For k up to N-2, a 0 decision sets `sw_p[k]` and a 1 decision sets `sw_n[k]`. Set lines stay set until the conversion ends, and no index has both lines set.
- R5: During a conversion exactly one select is active. The strobe for decision k finds select index 0 for k = 0 or 1, and index k-1 for k of 2 or more.
- R6: The strobe for a later decision rises max(1, `settle`)+1 clock cycles after the cycle in which both comparator outputs return low. It never rises in the cycle in which a switch line changes.
- R7: One cycle after the last decision is accepted, `done` pulses for one cycle with `code` holding the N decisions, first decision in bit N-1. Once the comparator outputs are low again, `sampling` returns with all switch lines 0.
- R8: If both comparator outputs are high while a decision is awaited, `err` pulses for one cycle. In that same cycle `sampling` is 1 and all switch lines are 0, and no `done` is given.
- R9: If no valid decision arrives, `err` pulses and sampling resumes exactly TMO_CYC+1 cycles after the strobe was seen.
- R10: Edges of `smp_clk` during a conversion are ignored, and the resulting code is unchanged.
- R11: `cmp_start` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_clk | input | 1 | Sample-rate clock; its falling edge starts a conversion |
| settle | input | SETW | Settle wait in cycles after each switch update (0 acts as 1) |
| cmp_p | input | 1 | Comparator positive output |
| cmp_n | input | 1 | Comparator negative output |
| sampling | output | 1 | Sampling switches closed |
| cmp_start | output | 1 | Comparator start strobe |
| sw_p | output | NBITS-1 | Positive-side bottom-plate controls, shared by all sub-arrays |
| sw_n | output | NBITS-1 | Negative-side bottom-plate controls, shared by all sub-arrays |
| sub_sel | output | NBITS-1 | Sub-array to comparator connection selects |
| code | output | NBITS | Last completed conversion result |
| done | output | 1 | One-cycle pulse when a new code is latched |
| err | output | 1 | One-cycle pulse on a clashing or missing decision |

## Verification
Two functions can land in the same cycle: accepting a decision, and seeing an edge of the sample-rate clock. The bench provokes this by raising and dropping `smp_clk` at fixed offsets inside a running conversion. The result is judged by an unchanged code and by correct strobe spacing and select positions at every strobe. The abort path also merges two actions into one cycle, raising the error and clearing every switch line. A clash is injected after several switch lines are already set, and the bench checks that both actions appear at the same sampling point.

// File: rtl/sar_handoff_ctrl.sv
module sar_handoff_ctrl #(
  parameter int NBITS   = 10,
  parameter int SETW    = 4,
  parameter int TMO_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_clk,
  input  logic [SETW-1:0]  settle,
  input  logic             cmp_p,
  input  logic             cmp_n,
  output logic             sampling,
  output logic             cmp_start,
  output logic [NBITS-2:0] sw_p,
  output logic [NBITS-2:0] sw_n,
  output logic [NBITS-2:0] sub_sel,
  output logic [NBITS-1:0] code,
  output logic             done,
  output logic             err
);
  localparam int NSW = NBITS - 1;
  localparam int KW  = $clog2(NBITS);
  localparam int TW  = $clog2(TMO_CYC + 1);

  typedef enum logic [2:0] {ST_SAMP, ST_FIRE, ST_WAIT, ST_RST, ST_SETL} st_t;

  st_t              st;
  logic             smp_q, rdy;
  logic [KW-1:0]    k;
  logic [NBITS-1:1] dec;
  logic [NSW-1:0]   sel;
  logic [SETW-1:0]  scnt;
  logic [TW-1:0]    tcnt;

  wire            fall  = smp_q & ~smp_clk;
  wire            valid = cmp_p ^ cmp_n;
  wire            clash = cmp_p & cmp_n;
  wire            quiet = ~cmp_p & ~cmp_n;
  wire [SETW-1:0] eff   = (settle == '0) ? SETW'(1) : settle;
  wire [KW-1:0]   didx  = KW'(NBITS - 1) - k;
  wire            last  = (k == KW'(NBITS - 1));
  wire            tmo   = (tcnt == TW'(TMO_CYC - 1));

  assign sampling  = (st == ST_SAMP);
  assign cmp_start = (st == ST_FIRE);
  assign sub_sel   = sampling ? '1 : sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_SAMP;
      smp_q <= 1'b0;
      rdy  <= 1'b0;
      k    <= '0;
      dec  <= '0;
      sel  <= NSW'(1);
      sw_p <= '0;
      sw_n <= '0;
      scnt <= '0;
      tcnt <= '0;
      code <= '0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      smp_q <= smp_clk;
      done  <= 1'b0;
      err   <= 1'b0;
      unique case (st)
        ST_SAMP: begin
          sw_p <= '0;
          sw_n <= '0;
          sel  <= NSW'(1);
          k    <= '0;
          dec  <= '0;
          rdy  <= 1'b0;
          if (fall) st <= ST_FIRE;
        end
        ST_FIRE: begin
          tcnt <= '0;
          st   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (clash) begin
            err  <= 1'b1;
            sw_p <= '0;
            sw_n <= '0;
            st   <= ST_SAMP;
          end else if (valid) begin
            if (last) begin
              rdy  <= 1'b1;
              code <= {dec, cmp_p};
              done <= 1'b1;
            end else begin
              dec[didx] <= cmp_p;
              if (cmp_p) sw_n[k] <= 1'b1;
              else       sw_p[k] <= 1'b1;
              if (k != '0) sel <= sel << 1;
              k <= k + KW'(1);
            end
            tcnt <= '0;
            st   <= ST_RST;
          end else if (tmo) begin
            err  <= 1'b1;
            sw_p <= '0;
            sw_n <= '0;
            st   <= ST_SAMP;
          end else begin
            tcnt <= tcnt + TW'(1);
          end
        end
        ST_RST: begin
          if (quiet) begin
            if (rdy) begin
              sw_p <= '0;
              sw_n <= '0;
              st   <= ST_SAMP;
            end else begin
              scnt <= eff;
              st   <= ST_SETL;
            end
          end else if (tmo) begin
            err  <= 1'b1;
            sw_p <= '0;
            sw_n <= '0;
            st   <= ST_SAMP;
          end else begin
            tcnt <= tcnt + TW'(1);
          end
        end
        ST_SETL: begin
          if (scnt <= SETW'(1)) st <= ST_FIRE;
          else                  scnt <= scnt - SETW'(1);
        end
        default: st <= ST_SAMP;
      endcase
    end
  end

  // R2
  samp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampling |-> (sw_p == '0 && sw_n == '0));

  // R4
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_p & sw_n) == '0);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sampling |=> (sampling || ((($past(sw_p) & ~sw_p) == '0) && (($past(sw_n) & ~sw_n) == '0))));

  // R5
  sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sampling |-> ($countones(sub_sel) == 1));

  // R6
  settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampling && (sw_p != $past(sw_p) || sw_n != $past(sw_n))) |-> !cmp_start);

  // R11
  strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_start |=> !cmp_start);

  // R7
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (sampling && !done && sw_p == '0 && sw_n == '0));
endmodule

// File: tb/sar_handoff_ctrl_tb.sv
module sar_handoff_ctrl_tb;
  localparam int NBITS = 10;
  localparam int SETW  = 4;
  localparam int TMO   = 64;
  localparam int NSW   = NBITS - 1;

  // vin[15:6], settle[5:2], latency[1:0]
  localparam logic [15:0] VEC [0:5] = '{
    {10'd0,    4'd0,  2'd1},
    {10'd1023, 4'd1,  2'd2},
    {10'd512,  4'd3,  2'd3},
    {10'd511,  4'd5,  2'd1},
    {10'd341,  4'd15, 2'd2},
    {10'd682,  4'd2,  2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, smp_clk = 1'b1;
  logic [SETW-1:0] settle = '0;
  logic cmp_p = 1'b0, cmp_n = 1'b0;
  logic sampling, cmp_start, done, err;
  logic [NSW-1:0] sw_p, sw_n, sub_sel;
  logic [NBITS-1:0] code;

  int checks = 0, fails = 0, cyc = 0;
  int vin_g = 0, eff_g = 1, lat_g = 1, mode_g = 0, fault_at = 0, kk = 0;
  int drop_cyc = 0, strobe_cyc = 0;

  sar_handoff_ctrl #(.NBITS(NBITS), .SETW(SETW), .TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_clk(smp_clk), .settle(settle),
    .cmp_p(cmp_p), .cmp_n(cmp_n), .sampling(sampling), .cmp_start(cmp_start),
    .sw_p(sw_p), .sw_n(sw_n), .sub_sel(sub_sel), .code(code), .done(done), .err(err));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  // behavioural comparator
  initial begin
    forever begin
      @(negedge clk);
      if (cmp_start) begin
        logic [NSW-1:0] ep, en, es;
        bit b;
        strobe_cyc = cyc;
        es = NSW'(1) << ((kk < 2) ? 0 : kk - 1);
        chk(sub_sel == es, "R5 select", int'(sub_sel), int'(es));
        if (kk == 0) chk(sw_p == '0 && sw_n == '0, "R3 msb unswitched", int'(sw_p | sw_n), 0);
        else chk(cyc - drop_cyc == eff_g + 1, "R6 settle gap", cyc - drop_cyc, eff_g + 1);
        ep = '0; en = '0;
        for (int j = 0; j < NSW; j++)
          if (j < kk) begin
            en[j] = vin_g[NBITS-1-j];
            ep[j] = ~vin_g[NBITS-1-j];
          end
        chk(sw_p == ep && sw_n == en, "R4 switch lines", int'({sw_p, sw_n}), int'({ep, en}));
        b = vin_g[NBITS-1-kk];
        @(negedge clk);
        chk(!cmp_start, "R11 strobe width", int'(cmp_start), 0);
        repeat (lat_g - 1) @(negedge clk);
        if (mode_g == 2 && kk == fault_at) begin
          kk++;
        end else begin
          if (mode_g == 1 && kk == fault_at) {cmp_p, cmp_n} = 2'b11;
          else {cmp_p, cmp_n} = b ? 2'b10 : 2'b01;
          @(negedge clk);
          cmp_p = 1'b0; cmp_n = 1'b0;
          drop_cyc = cyc;
          kk++;
        end
      end
    end
  end

  task automatic arm(input int v, input int s, input int l);
    vin_g = v; settle = SETW'(s); eff_g = (s == 0) ? 1 : s; lat_g = l; kk = 0;
    @(negedge clk) smp_clk = 1'b1;
    repeat (2) @(negedge clk);
    chk(sampling && sw_p == '0 && sw_n == '0 && sub_sel == '1, "R2 sampling idle",
        int'({sampling, sw_p | sw_n, sub_sel}), int'({1'b1, {NSW{1'b0}}, {NSW{1'b1}}}));
    smp_clk = 1'b0;
  endtask

  task automatic convert(input int v, input int s, input int l, input bit tog);
    bit got = 0;
    mode_g = 0;
    arm(v, s, l);
    for (int i = 0; i < 3000 && !got; i++) begin
      @(negedge clk);
      if (tog && i == 20) smp_clk = 1'b1;
      if (tog && i == 23) smp_clk = 1'b0;
      if (done) got = 1;
    end
    chk(got && code == NBITS'(v), tog ? "R10 code with sample edges" : "R7 code", int'(code), v);
    @(negedge clk);
    chk(!done && sampling && sw_p == '0 && sw_n == '0, "R7 done pulse and resample",
        int'({done, sampling, sw_p | sw_n}), int'({1'b0, 1'b1, {NSW{1'b0}}}));
    chk(kk == NBITS, "R7 decision count", kk, NBITS);
  endtask

  task automatic fault(input int m, input int at);
    bit got = 0, sawdone = 0;
    int ecyc = 0;
    mode_g = m; fault_at = at;
    arm(10'h2C6, 1, 1);
    for (int i = 0; i < 500 && !got; i++) begin
      @(negedge clk);
      if (done) sawdone = 1;
      if (err) begin
        got = 1;
        ecyc = cyc;
        chk(sampling && sw_p == '0 && sw_n == '0, m == 1 ? "R8 abort state" : "R9 abort state",
            int'({sampling, sw_p | sw_n}), int'({1'b1, {NSW{1'b0}}}));
      end
    end
    chk(got && !sawdone, m == 1 ? "R8 error raised" : "R9 error raised", int'({got, sawdone}), 2);
    if (m == 2) chk(ecyc - strobe_cyc == TMO + 1, "R9 timeout length", ecyc - strobe_cyc, TMO + 1);
    @(negedge clk);
    chk(!err, "R8 error pulse width", int'(err), 0);
    mode_g = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sampling && !cmp_start && !done && !err && sw_p == '0 && sw_n == '0 &&
        sub_sel == '1 && code == '0, "R1 reset state",
        int'({sampling, cmp_start, done, err}), 8);
    for (int v = 0; v < 6; v++)
      convert(int'(VEC[v][15:6]), int'(VEC[v][5:2]), int'(VEC[v][1:0]), 1'b0);
    convert(10'h2A5, 2, 1, 1'b1);
    fault(1, 3);
    fault(2, 2);
    convert(10'h13B, 4, 2, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule